// File: doc/BRIEF.md
# Prescaled Reload Timer

A down-counting timer driven by the system clock through two cascaded stages. A 16-bit prescale counter counts clock cycles. Each time it passes zero it refills from a divide-down value and sends one step to a 32-bit main counter. When the main counter passes zero, it refills from a 32-bit period value and emits a one-cycle interrupt pulse. A sticky interrupt flag records each such event.

Software uses a small word-addressed register port with 16-bit data. Through it, software sets the period and the divide-down value, reads or overwrites the counter, halts and resumes counting, forces an immediate refill of both stages, and acknowledges the interrupt flag. Reads are combinational from the address. Writes take effect at the clock edge where `wr_en` is high.

Top module: `reload_timer`

## Requirements
- R1: While reset is held, the counter reads 0xFFFF in both halves, the period reads 0xFFFF in both halves, and the divide-down value, the prescale counter and the control word all read 0. The interrupt output is low, and counting starts once reset is released.
- R2: With divide-down value N, the prescaler counts N, N-1, ..., 0 and then refills with N. The main counter decreases by one only at the edge where the prescaler is at 0, so it steps once every N+1 clocks.
- R3: When the main counter steps while at 0, it loads the period P and `irq` is high for the following cycle. Interrupts therefore come every (P+1)(N+1) clocks, measured from the edge at which counting starts.
- R4: Control bit 15 is a sticky flag that is set together with each `irq` pulse. Writing 1 to it clears it, and writing 0 leaves it unchanged. If a clear and a new interrupt fall on the same edge, the flag stays set.
- R5: Control bit 4 is the stop bit. While it is 1, neither counter changes and `irq` stays low. It reads back as written.
- R6: Writing 1 to control bit 5 loads the counter from the period and the prescaler from the divide-down value at that edge, even while stopped. No step and no interrupt happen at that edge, and the bit always reads 0.
- R7: The address map is: 0 counter low, 1 counter high, 2 period low, 3 period high, 4 control, 5 prescale counter, 6 divide-down value. Each half can be written on its own. Address 5 is read-only and ignores writes, and address 7 reads 0.
- R8: A write to either counter half stores that half and suppresses the step of both stages at that edge. Counting resumes on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
Two events can land on the same edge as a main-counter borrow: a software acknowledge of the interrupt flag, and a forced reload. The bench starts the timer with a period of 3 and a divide-down value of 0, then issues each write exactly four edges after the start. In the first case it expects the pulse to appear and the flag to remain set. In the second it expects no pulse, a clear flag and the counter back at the period value.

// File: rtl/reload_timer.sv
module reload_timer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq
);
  localparam logic [2:0] A_CNTL = 3'd0, A_CNTH = 3'd1, A_PRDL = 3'd2, A_PRDH = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4, A_PSC  = 3'd5, A_DIV  = 3'd6;
  localparam int BIT_STOP = 4, BIT_RLD = 5, BIT_FLAG = 15;

  logic [31:0] cnt, prd;
  logic [15:0] psc, divv;
  logic        stop, flag;

  wire wr_ctrl = wr_en && (addr == A_CTRL);
  wire reload  = wr_ctrl && wdata[BIT_RLD];
  wire wr_cnt  = wr_en && (addr == A_CNTL || addr == A_CNTH);
  wire run     = !stop && !reload && !wr_cnt;
  wire tick    = run && (psc == 16'd0);
  wire borrow  = tick && (cnt == 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '1;
      prd  <= '1;
      psc  <= '0;
      divv <= '0;
      stop <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      irq <= borrow;

      if (reload) begin
        cnt <= prd;
        psc <= divv;
      end else if (wr_cnt) begin
        if (addr == A_CNTL) cnt[15:0]  <= wdata;
        else                cnt[31:16] <= wdata;
      end else if (run) begin
        if (tick) begin
          psc <= divv;
          cnt <= borrow ? prd : cnt - 32'd1;
        end else begin
          psc <= psc - 16'd1;
        end
      end

      if (wr_en && addr == A_PRDL) prd[15:0]  <= wdata;
      if (wr_en && addr == A_PRDH) prd[31:16] <= wdata;
      if (wr_en && addr == A_DIV)  divv       <= wdata;
      if (wr_ctrl)                 stop       <= wdata[BIT_STOP];

      if (borrow)                           flag <= 1'b1;
      else if (wr_ctrl && wdata[BIT_FLAG])  flag <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CNTL: rdata = cnt[15:0];
      A_CNTH: rdata = cnt[31:16];
      A_PRDL: rdata = prd[15:0];
      A_PRDH: rdata = prd[31:16];
      A_CTRL: begin
        rdata[BIT_STOP] = stop;
        rdata[BIT_FLAG] = flag;
      end
      A_PSC:  rdata = psc;
      A_DIV:  rdata = divv;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [2:0]  addr,
  input logic [15:0] wdata,
  input logic        irq,
  input logic [31:0] cnt,
  input logic [31:0] prd,
  input logic [15:0] psc,
  input logic [15:0] divv,
  input logic        stop,
  input logic        flag
);
  p_prescale_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(stop) && !$past(wr_en) && $past(psc) != 16'd0)
      |-> (psc == $past(psc) - 16'd1) && $stable(cnt));

  p_borrow_loads_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !$past(wr_en)) |-> (cnt == prd));

  p_irq_sets_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag);

  p_flag_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(addr) == 3'd4 && $past(wdata[15]) && !irq) |-> !flag);

  p_stop_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop) && !$past(wr_en)) |-> ($stable(cnt) && $stable(psc) && !irq));

  p_forced_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && $past(addr) == 3'd4 && $past(wdata[5]))
      |-> (cnt == $past(prd) && psc == $past(divv) && !irq));
endmodule

bind reload_timer reload_timer_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .irq(irq), .cnt(cnt), .prd(prd), .psc(psc), .divv(divv),
  .stop(stop), .flag(flag)
);

// File: tb/tb_reload_timer.sv
`timescale 1ns/100ps
module tb_reload_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [15:0] wdata = 16'd0;
  logic [15:0] rdata;
  logic        irq;

  int tests = 0;
  int fails = 0;

  reload_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2 clk = ~clk;

  // {divide-down N, period P, expected interval (P+1)*(N+1)}
  localparam int NV = 5;
  localparam logic [63:0] VEC [NV] = '{
    {16'd0, 32'd0, 16'd1},
    {16'd0, 32'd3, 16'd4},
    {16'd2, 32'd4, 16'd15},
    {16'd4, 32'd1, 16'd10},
    {16'd1, 32'd9, 16'd20}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #0.1 d = rdata;
  endtask

  task automatic until_irq(output int n);
    n = 0;
    do begin
      @(posedge clk); #1; n++;
    end while (!irq && n < 5000);
  endtask

  task automatic setup(input logic [15:0] n, input logic [31:0] p);
    wr(3'd4, 16'h0010);
    wr(3'd6, n);
    wr(3'd2, p[15:0]);
    wr(3'd3, p[31:16]);
    wr(3'd4, 16'h0030);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d, a0, b0;
    int n;
    bit seen;

    repeat (3) @(posedge clk);
    #1;
    // R1 reset values
    rd(3'd0, d); check("R1 cnt lo", d, 16'hFFFF);
    rd(3'd1, d); check("R1 cnt hi", d, 16'hFFFF);
    rd(3'd2, d); check("R1 prd lo", d, 16'hFFFF);
    rd(3'd3, d); check("R1 prd hi", d, 16'hFFFF);
    rd(3'd4, d); check("R1 ctrl", d, 16'h0000);
    rd(3'd5, d); check("R1 psc", d, 16'h0000);
    rd(3'd6, d); check("R1 div", d, 16'h0000);
    check("R1 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd(3'd0, d); check("R1 runs after reset", d, 16'hFFFE);

    // Vector table: R2 / R3 interval, R4 flag, R6 read-as-zero
    for (int i = 0; i < NV; i++) begin
      setup(VEC[i][63:48], VEC[i][47:16]);
      rd(3'd4, d); check("R6 reload bit reads 0", d, 16'h0010);
      rd(3'd0, d); check("R6 cnt loaded", d, VEC[i][31:16]);
      wr(3'd4, 16'h0000);
      until_irq(n); check("R3 first interval", n, VEC[i][15:0]);
      rd(3'd0, d); check("R3 reload from period", d, VEC[i][31:16]);
      rd(3'd4, d); check("R4 flag set", d[15], 1'b1);
      until_irq(n); check("R2 second interval", n, VEC[i][15:0]);
      wr(3'd4, 16'h8010);
      wr(3'd4, 16'h8010);
      rd(3'd4, d); check("R4 flag cleared", d, 16'h0010);
    end

    // R2 prescaler sequence N=2
    setup(16'd2, 32'd100);
    wr(3'd4, 16'h0000);
    rd(3'd5, d); check("R2 psc first", d, 16'd2);
    @(posedge clk); #1; rd(3'd5, d); check("R2 psc step", d, 16'd1);
    @(posedge clk); #1; rd(3'd5, d); check("R2 psc zero", d, 16'd0);
    rd(3'd0, d); check("R2 cnt held", d, 16'd100);
    @(posedge clk); #1; rd(3'd5, d); check("R2 psc refill", d, 16'd2);
    rd(3'd0, d); check("R2 cnt step", d, 16'd99);

    // R4 writing 0 to flag has no effect
    setup(16'd0, 32'd0);
    wr(3'd4, 16'h0000);
    wr(3'd4, 16'h0010);
    rd(3'd4, d); check("R4 flag kept", d, 16'h8010);
    wr(3'd4, 16'h0010);
    rd(3'd4, d); check("R4 write 0 ignored", d, 16'h8010);
    wr(3'd4, 16'h8010);

    // R4 set wins over clear on the same edge
    setup(16'd0, 32'd3);
    wr(3'd4, 16'h0000);
    repeat (3) @(posedge clk);
    #1;
    wr(3'd4, 16'h8000);
    check("R4 irq at collision", irq, 1'b1);
    rd(3'd4, d); check("R4 set wins", d[15], 1'b1);
    wr(3'd4, 16'h8010);
    rd(3'd4, d); check("R4 cleared after", d, 16'h0010);

    // R6 forced reload overrides borrow
    setup(16'd0, 32'd3);
    wr(3'd4, 16'h0000);
    repeat (3) @(posedge clk);
    #1;
    wr(3'd4, 16'h0020);
    check("R6 no irq on reload edge", irq, 1'b0);
    rd(3'd4, d); check("R6 flag untouched", d, 16'h0000);
    rd(3'd0, d); check("R6 cnt from period", d, 16'd3);

    // R8 counter write overrides counting
    wr(3'd0, 16'h0005);
    rd(3'd0, d); check("R8 cnt lo written", d, 16'h0005);
    @(posedge clk); #1;
    rd(3'd0, d); check("R8 resumes", d, 16'h0004);

    // R5 stop freezes
    setup(16'd0, 32'd2);
    rd(3'd0, a0); rd(3'd5, b0);
    seen = 0;
    for (int k = 0; k < 20; k++) begin
      @(posedge clk); #1;
      if (irq) seen = 1;
    end
    rd(3'd0, d); check("R5 cnt frozen", d, a0);
    rd(3'd5, d); check("R5 psc frozen", d, b0);
    check("R5 no irq while stopped", seen, 1'b0);
    rd(3'd4, d); check("R5 stop reads back", d, 16'h0010);

    // R7 map details
    wr(3'd6, 16'h0003);
    wr(3'd4, 16'h0030);
    wr(3'd5, 16'h1234);
    rd(3'd5, d); check("R7 psc read-only", d, 16'h0003);
    rd(3'd7, d); check("R7 addr 7 reads 0", d, 16'h0000);
    wr(3'd3, 16'hABCD);
    rd(3'd2, d); check("R7 prd lo independent", d, 16'h0002);
    rd(3'd3, d); check("R7 prd hi written", d, 16'hABCD);
    wr(3'd1, 16'h00C0);
    rd(3'd1, d); check("R7 cnt hi written", d, 16'h00C0);
    rd(3'd0, d); check("R7 cnt lo independent", d, 16'h0002);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule